// File: doc/BRIEF.md
# Half-Symbol-Spaced Adaptive PAM4 Equalizer

This block is the linear equalizer of a four-level PAM receiver. Each symbol period it takes two samples, taken half a symbol apart, and pushes them into a delay line of odd length L. It then forms one equalized value per symbol, so the sample rate drops by two. A slicer picks the nearest of the four amplitude levels. The error between the equalized value and a reference symbol drives a least-mean-square update of every coefficient.

After reset the block trains against a known symbol stream, supplied beside the samples, for a programmable number of symbols. It then uses its own slicer decisions as the reference, and stays in that mode until the next reset. The two coefficients on either side of the centre tap are presented on their own ports, once per symbol. A timing loop in front of the equalizer can form its phase error from their difference.

Top module: `fse_lms_eq`

## Requirements
- R1: While reset is high and on the first cycle after it, the centre coefficient (position C = (L-1)/2) is 2^CF and all other coefficients are zero. out_valid, out_y, out_code, out_dd, tap_pre and tap_post are all zero, and the block is in training mode.
- R2: Each cycle with in_valid high accepts one symbol's sample pair and yields exactly one output symbol. out_valid is high for one cycle exactly two clock edges after the edge that captured the pair.
- R3: Window position 0 holds samp_late of the newest pair and position 1 holds its samp_early. Position j holds the sample j half-symbols older, and positions not yet filled since reset hold zero. out_y equals floor(sum of h_i·x_i / 2^CF), saturated to DW+2 signed bits.
- R4: The slicer codes are 0 for level −3, 1 for −1, 2 for +1 and 3 for +3, where one level unit is 2^SF. The decision is 0 when y < −2·2^SF, 1 when −2·2^SF ≤ y < 0, 2 when 0 ≤ y < 2·2^SF, and 3 otherwise. A value exactly on a threshold goes to the upper code.
- R5: In training mode the error is y minus level(train_code)·2^SF, where train_code is sampled together with its sample pair and uses the R4 coding.
- R6: The first TRAIN_LEN symbols after reset use training mode. Every later symbol uses decision-directed mode, and the mode never returns to training without a reset. out_dd reports the mode used for the symbol on out_y.
- R7: In decision-directed mode the error is y minus level(out_code)·2^SF, using the slicer decision of the same symbol.
- R8: After each symbol, every coefficient becomes sat(h_i − floor(e·x_i / 2^MU_SH)) to CW signed bits. Here e and x_i belong to that symbol's window. The next symbol uses the new coefficients, and coefficients change at no other time.
- R9: tap_pre and tap_post carry the coefficients at positions C−1 and C+1 that produced the current output symbol. They change only together with out_valid.
- R10: A reset in mid-run restores the R1 state. The window is cleared, and the training count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies one symbol's sample pair and training code |
| samp_early | input | DW | Earlier half-symbol sample, signed |
| samp_late | input | DW | Later half-symbol sample, signed |
| train_code | input | 2 | Training symbol code (R4 coding) |
| out_valid | output | 1 | Qualifies the output symbol |
| out_y | output | DW+2 | Equalized value, signed |
| out_code | output | 2 | Slicer decision |
| out_dd | output | 1 | High when the symbol used decision-directed adaptation |
| tap_pre | output | CW | Coefficient at centre−1, signed |
| tap_post | output | CW | Coefficient at centre+1, signed |

## Verification
Every result of a symbol appears on the ports exactly two edges after its pair is captured. This covers the equalized value, the decision, the mode flag and the two timing taps. The driver stamps each expected item with the cycle count at which it is due. The monitor samples on the falling edge and compares that stamp as well as the values, so a symbol that arrives one cycle early or late fails. Because a coefficient update feeds the very next symbol, the bench's arithmetic model runs in symbol order. Sending symbols back to back then checks that the update lands one edge before the next window is used.

// File: rtl/fse_pkg.sv
package fse_pkg;
  function automatic int pam_level(input logic [1:0] c);
    case (c)
      2'd0:    return -3;
      2'd1:    return -1;
      2'd2:    return 1;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/fse_delay_line.sv
module fse_delay_line #(
  parameter int L  = 11,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] samp_early,
  input  logic signed [DW-1:0] samp_late,
  output logic signed [DW-1:0] win [L],
  output logic                 win_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      win_vld <= 1'b0;
      for (int j = 0; j < L; j++) win[j] <= '0;
    end else begin
      win_vld <= in_valid;
      if (in_valid) begin
        win[0] <= samp_late;
        win[1] <= samp_early;
        for (int j = 2; j < L; j++) win[j] <= win[j-2];
      end
    end
  end
endmodule

// File: rtl/fse_mac.sv
module fse_mac #(
  parameter int L  = 11,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int CF = 12,
  parameter int OW = 10
) (
  input  logic signed [DW-1:0] win  [L],
  input  logic signed [CW-1:0] coef [L],
  output logic signed [OW-1:0] y
);
  localparam int PW = DW + CW;
  localparam int AW = PW + $clog2(L);
  localparam logic signed [AW-1:0] YMAX = AW'(2**(OW-1) - 1);
  localparam logic signed [AW-1:0] YMIN = AW'(-(2**(OW-1)));

  logic signed [PW-1:0] prod [L];
  logic signed [AW-1:0] acc, yf;

  for (genvar i = 0; i < L; i++) begin : g_prod
    assign prod[i] = coef[i] * win[i];
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < L; i++) acc = acc + AW'(prod[i]);
    yf = acc >>> CF;
    if (yf > YMAX)      y = OW'(YMAX);
    else if (yf < YMIN) y = OW'(YMIN);
    else                y = yf[OW-1:0];
  end
endmodule

// File: rtl/fse_slicer.sv
module fse_slicer #(
  parameter int OW = 10,
  parameter int SF = 5
) (
  input  logic signed [OW-1:0] y,
  output logic [1:0]           code
);
  localparam logic signed [OW-1:0] THR_P = OW'(2 * (2**SF));
  localparam logic signed [OW-1:0] THR_N = OW'(-2 * (2**SF));

  always_comb begin
    if (y < THR_N)      code = 2'd0;
    else if (y[OW-1])   code = 2'd1;
    else if (y < THR_P) code = 2'd2;
    else                code = 2'd3;
  end
endmodule

// File: rtl/fse_coef_bank.sv
module fse_coef_bank #(
  parameter int L     = 11,
  parameter int DW    = 8,
  parameter int CW    = 16,
  parameter int CF    = 12,
  parameter int EW    = 11,
  parameter int MU_SH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_en,
  input  logic signed [EW-1:0] err,
  input  logic signed [DW-1:0] win  [L],
  output logic signed [CW-1:0] coef [L]
);
  localparam int C  = (L - 1) / 2;
  localparam int UW = ((EW + DW > CW) ? EW + DW : CW) + 1;
  localparam logic signed [UW-1:0] CMAX = UW'(2**(CW-1) - 1);
  localparam logic signed [UW-1:0] CMIN = UW'(-(2**(CW-1)));

  for (genvar i = 0; i < L; i++) begin : g_tap
    logic signed [EW+DW-1:0] prod;
    logic signed [EW+DW-1:0] step;
    logic signed [UW-1:0]    nxt;

    assign prod = err * win[i];
    assign step = prod >>> MU_SH;
    assign nxt  = UW'(coef[i]) - UW'(step);

    always_ff @(posedge clk) begin
      if (rst)
        coef[i] <= (i == C) ? CW'(2**CF) : '0;
      else if (upd_en) begin
        if (nxt > CMAX)      coef[i] <= CW'(CMAX);
        else if (nxt < CMIN) coef[i] <= CW'(CMIN);
        else                 coef[i] <= nxt[CW-1:0];
      end
    end

    // R8: coefficients move only on a symbol update
    a_r8_hold_between_symbols: assert property (@(posedge clk) disable iff (rst)
      !upd_en |=> $stable(coef[i]));
  end
endmodule

// File: rtl/fse_lms_eq.sv
module fse_lms_eq #(
  parameter int L         = 11,
  parameter int DW        = 8,
  parameter int CW        = 16,
  parameter int CF        = 12,
  parameter int SF        = 5,
  parameter int MU_SH     = 8,
  parameter int TRAIN_LEN = 3000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   samp_early,
  input  logic signed [DW-1:0]   samp_late,
  input  logic [1:0]             train_code,
  output logic                   out_valid,
  output logic signed [DW+1:0]   out_y,
  output logic [1:0]             out_code,
  output logic                   out_dd,
  output logic signed [CW-1:0]   tap_pre,
  output logic signed [CW-1:0]   tap_post
);
  localparam int OW   = DW + 2;
  localparam int EW   = OW + 1;
  localparam int C    = (L - 1) / 2;
  localparam int CNTW = $clog2(TRAIN_LEN + 2);

  logic signed [DW-1:0] win  [L];
  logic signed [CW-1:0] coef [L];
  logic                 win_vld;
  logic [1:0]           trn_q, dec, ref_code;
  logic signed [OW-1:0] y;
  logic signed [EW-1:0] ref_v, err;
  logic [CNTW-1:0]      cnt;
  logic                 dd_now;

  fse_delay_line #(.L(L), .DW(DW)) u_dl (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .samp_early(samp_early), .samp_late(samp_late),
    .win(win), .win_vld(win_vld));

  fse_mac #(.L(L), .DW(DW), .CW(CW), .CF(CF), .OW(OW)) u_mac (
    .win(win), .coef(coef), .y(y));

  fse_slicer #(.OW(OW), .SF(SF)) u_slc (.y(y), .code(dec));

  fse_coef_bank #(.L(L), .DW(DW), .CW(CW), .CF(CF), .EW(EW), .MU_SH(MU_SH)) u_cb (
    .clk(clk), .rst(rst), .upd_en(win_vld), .err(err), .win(win), .coef(coef));

  assign dd_now   = (cnt == CNTW'(TRAIN_LEN));
  assign ref_code = dd_now ? dec : trn_q;
  assign ref_v    = EW'(fse_pkg::pam_level(ref_code) * (2**SF));
  assign err      = EW'(y) - ref_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      trn_q     <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_y     <= '0;
      out_code  <= '0;
      out_dd    <= 1'b0;
      tap_pre   <= '0;
      tap_post  <= '0;
    end else begin
      if (in_valid) trn_q <= train_code;
      out_valid <= win_vld;
      if (win_vld) begin
        if (!dd_now) cnt <= cnt + 1'b1;
        out_y    <= y;
        out_code <= dec;
        out_dd   <= dd_now;
        tap_pre  <= coef[C-1];
        tap_post <= coef[C+1];
      end
    end
  end

  // R2: one output two edges after each accepted pair
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  // R6: decision-directed mode is sticky
  a_r6_dd_sticky: assert property (@(posedge clk) disable iff (rst)
    out_dd |=> out_dd);
  // R4: upper two codes exactly for non-negative values
  a_r4_code_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_code[1] == !out_y[OW-1]));
  // R9: timing taps move only with an output symbol
  a_r9_tap_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(tap_pre) && $stable(tap_post)));
endmodule

// File: tb/sim_fse_lms_eq.sv
module sim_fse_lms_eq;
  localparam int CLK_PER = 10;
  localparam int L = 11, DW = 8, CW = 16, CF = 12, SF = 5, MU_SH = 8, TRAIN = 24;
  localparam int OW = DW + 2;
  localparam int C  = (L - 1) / 2;

  typedef struct {
    int y; int code; int dd; int tp; int tq; int cyc; int first;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [DW-1:0] samp_early = '0, samp_late = '0;
  logic [1:0] train_code = '0;
  logic out_valid, out_dd;
  logic signed [OW-1:0] out_y;
  logic [1:0] out_code;
  logic signed [CW-1:0] tap_pre, tap_post;

  fse_lms_eq #(.L(L), .DW(DW), .CW(CW), .CF(CF), .SF(SF), .MU_SH(MU_SH), .TRAIN_LEN(TRAIN)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .samp_early(samp_early), .samp_late(samp_late),
    .train_code(train_code), .out_valid(out_valid), .out_y(out_y), .out_code(out_code),
    .out_dd(out_dd), .tap_pre(tap_pre), .tap_post(tap_post));

  always #(CLK_PER/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, sent = 0, got = 0;
  bit done = 0, first_pending = 0;
  exp_t q[$];
  int w[L];
  int h[L];
  int nsym;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int lvl(int c);
    return (c == 0) ? -3 : (c == 1) ? -1 : (c == 2) ? 1 : 3;
  endfunction

  function automatic int sat(longint v, int bits);
    longint mx = (64'sd1 <<< (bits - 1)) - 1;
    longint mn = -(64'sd1 <<< (bits - 1));
    if (v > mx) return int'(mx);
    if (v < mn) return int'(mn);
    return int'(v);
  endfunction

  task automatic model_reset();
    for (int j = 0; j < L; j++) begin w[j] = 0; h[j] = 0; end
    h[C] = 1 << CF;
    nsym = 0;
    first_pending = 1;
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic send(int e, int l, int tc);
    exp_t it;
    longint acc = 0;
    int y, code, dd, rf, err;
    samp_early = DW'(e); samp_late = DW'(l); train_code = 2'(tc); in_valid = 1'b1;
    for (int j = L - 1; j >= 2; j--) w[j] = w[j-2];
    w[1] = e; w[0] = l;
    for (int j = 0; j < L; j++) acc += longint'(h[j]) * w[j];
    y = sat(acc >>> CF, OW);
    if (y < -2 * (1 << SF)) code = 0;
    else if (y < 0) code = 1;
    else if (y < 2 * (1 << SF)) code = 2;
    else code = 3;
    dd = (nsym >= TRAIN) ? 1 : 0;
    rf = dd ? lvl(code) : lvl(tc);
    err = y - rf * (1 << SF);
    it.y = y; it.code = code; it.dd = dd; it.tp = h[C-1]; it.tq = h[C+1];
    it.cyc = cyc + 2; it.first = first_pending;
    first_pending = 0;
    for (int j = 0; j < L; j++) h[j] = sat(longint'(h[j]) - ((err * w[j]) >>> MU_SH), CW);
    nsym++;
    q.push_back(it);
    sent++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      got++;
      if (q.size() == 0) begin
        chk("R2 unexpected out_valid", 1, 0);
      end else begin
        exp_t it;
        it = q.pop_front();
        chk("R2 output cycle", cyc, it.cyc);
        chk(it.dd ? "R3 R7 R8 out_y" : "R3 R5 R8 out_y", int'(out_y), it.y);
        chk("R4 out_code", int'(out_code), it.code);
        chk("R6 out_dd", int'(out_dd), it.dd);
        chk("R9 tap_pre", int'(tap_pre), it.tp);
        chk("R9 tap_post", int'(tap_post), it.tq);
        if (it.first) chk("R10 taps zero after reset", int'(tap_pre) | int'(tap_post), 0);
      end
    end
  end

  task automatic check_reset(string tag);
    chk({tag, " out_valid"}, int'(out_valid), 0);
    chk({tag, " out_y"}, int'(out_y), 0);
    chk({tag, " out_code"}, int'(out_code), 0);
    chk({tag, " out_dd"}, int'(out_dd), 0);
    chk({tag, " tap_pre"}, int'(tap_pre), 0);
    chk({tag, " tap_post"}, int'(tap_post), 0);
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    int prev = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check_reset("R1");
    rst = 1'b0;
    @(negedge clk);
    // phase 1: training into decision-directed, with gaps
    for (int k = 0; k < 60; k++) begin
      int a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = int'(lf[1:0]);
      send(lvl(a) * 32 + prev * 6, lvl(a) * 20 + prev * 12, a);
      prev = lvl(a);
      if (lf[4]) idle(1 + int'(lf[6:5]));
    end
    idle(6);
    // phase 2: reset in mid-run
    rst = 1'b1;
    model_reset();
    idle(2);
    check_reset("R10");
    rst = 1'b0;
    @(negedge clk);
    // phase 3: back to back, including slicer threshold values
    for (int k = 0; k < 50; k++) begin
      int a, e;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = int'(lf[1:0]);
      case (k % 5)
        0: e = 0;
        1: e = 64;
        2: e = -64;
        default: e = lvl(a) * 32 + prev * 5;
      endcase
      send(e, lvl(a) * 24, a);
      prev = lvl(a);
    end
    idle(6);
    chk("R2 outputs equal inputs", got, sent);
    chk("R2 queue drained", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual %0d expected %0d outputs", got, sent);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule